// File: doc/BRIEF.md
# DMA Request Selector and Priority Arbiter

This block sits in front of a seven-channel DMA transfer engine. Every channel owns a four-bit source-select code that picks which peripheral request lines may wake it up; lines that share one code on a channel are OR-combined. A channel set for memory-to-memory operation needs no peripheral at all and requests for as long as it is enabled. A channel that is switched off never requests.

Among the requesting channels, one is granted at a time. Each channel carries a two-bit priority level. The highest level wins, and when levels are equal the lower channel index wins. The grant stays fixed while the engine moves the current data item. It is re-evaluated only on the cycle in which the engine pulses `xfer_done`. Register access, address generation and data movement belong to other blocks.

Top module: `dma_req_arbiter`

## Requirements
- R1: During and straight after synchronous active-low reset, `grant` is all zeros, `grant_idx` is 0 and `grant_valid` is 0.
- R2: Peripheral line s (0..41) is mapped to channel index s mod 7 under select code (s div 7) mod 5. An enabled channel whose select code matches a raised mapped line requests. With no grant active, that channel is granted on the next rising clock edge. Lines mapped to another code or to another channel have no effect.
- R3: Select code 0 of each channel c has two lines mapped to it, c and c+35. Either line on its own makes the channel request.
- R4: An enabled channel with its memory-to-memory bit set requests with every peripheral line low.
- R5: A channel whose enable bit is 0 never requests, whatever its memory-to-memory bit and its selected lines are.
- R6: Select codes 5 to 15 have no lines mapped and produce no request, even with every peripheral line high.
- R7: Among requesting channels, the highest two-bit priority level is granted. The levels are 00 low, 01 medium, 10 high and 11 very high.
- R8: Among requesting channels of equal level, the lowest channel index is granted.
- R9: Once granted, `grant` and `grant_idx` stay unchanged until `xfer_done` is sampled high. On that edge, the grant is reloaded from the current requests. With no requests, `grant_valid` falls to 0.
- R10: `grant` is one-hot or zero. `grant_valid` is 1 exactly when `grant` is non-zero. When it is non-zero, `grant` equals 1 shifted left by `grant_idx`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| periph_req | input | 42 | Peripheral request lines |
| ch_en | input | 7 | Per-channel enable |
| ch_m2m | input | 7 | Per-channel memory-to-memory self-request |
| ch_prio | input | 14 | Per-channel priority level, 2 bits per channel, channel c at bits [2c+1:2c] |
| ch_sel | input | 28 | Per-channel source-select code, 4 bits per channel, channel c at bits [4c+3:4c] |
| xfer_done | input | 1 | Pulse from the engine: the current data item has finished |
| grant | output | 7 | One-hot grant to the channel being served |
| grant_idx | output | 3 | Index of the granted channel |
| grant_valid | output | 1 | A channel is currently granted |

## Verification
A wrong routing table or enable gate shows at the ports one edge after the stimulus. The grant either goes to the wrong channel or fails to appear while the block is idle. A faulty priority compare or tie-break shows as the wrong index on the first grant after two or more channels request together. A broken hold register is seen on the first edge with `xfer_done` low while a higher-level channel is requesting, because the grant moves too early. A broken reload is seen one edge after `xfer_done`, when the grant stays where it was.

// File: rtl/dma_sel_pkg.sv
// Package: shared routing helpers for the DMA request selector.
// Assumes peripheral lines are spread round-robin over the channels and
// that consecutive groups of lines take consecutive select codes, wrapping
// after the number of mapped codes.
package dma_sel_pkg;

    // Channel index that peripheral line s feeds.
    function automatic int src_chan(input int s, input int n_ch);
        return s % n_ch;
    endfunction

    // Select code under which peripheral line s is visible.
    function automatic int src_code(input int s, input int n_ch, input int n_codes);
        return (s / n_ch) % n_codes;
    endfunction

endpackage

// File: rtl/dma_req_route.sv
// Module: dma_req_route
// Builds one request bit per channel from the peripheral lines, the channel's
// select code, its enable and its memory-to-memory bit.
// Assumes: lines that share a code on one channel are OR-combined; codes with
// no mapped line yield no request; a disabled channel never requests.
module dma_req_route
    import dma_sel_pkg::*;
#(
    parameter int NUM_CH  = 7,
    parameter int NUM_SRC = 42,
    parameter int SEL_W   = 4,
    parameter int N_CODES = 5
) (
    input  logic [NUM_SRC-1:0]      periph_req,
    input  logic [NUM_CH-1:0]       ch_en,
    input  logic [NUM_CH-1:0]       ch_m2m,
    input  logic [NUM_CH*SEL_W-1:0] ch_sel,
    output logic [NUM_CH-1:0]       chan_req
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [SEL_W-1:0] sel_c;
        logic             hit;

        assign sel_c = ch_sel[c*SEL_W +: SEL_W];

        // OR together every line mapped to this channel under its current code.
        always_comb begin
            hit = 1'b0;
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_chan(s, NUM_CH) == c &&
                    src_code(s, NUM_CH, N_CODES) == int'(sel_c)) begin
                    hit = hit | periph_req[s];
                end
            end
        end

        // Gate with enable; memory-to-memory mode requests on its own.
        assign chan_req[c] = ch_en[c] & (ch_m2m[c] | hit);
    end

endmodule

// File: rtl/dma_prio_pick.sv
// Module: dma_prio_pick
// Purely combinational winner selection among requesting channels.
// Assumes: a higher level value means a higher priority; on equal levels the
// lower channel index wins.
module dma_prio_pick #(
    parameter int NUM_CH = 7,
    parameter int PRIO_W = 2,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0]        chan_req,
    input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
    output logic                     win_found,
    output logic [IDX_W-1:0]         win_idx
);

    logic [PRIO_W-1:0] best_lvl;

    // Scan from the top index down; ">=" lets a lower index take over on ties.
    always_comb begin
        win_found = 1'b0;
        win_idx   = '0;
        best_lvl  = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (chan_req[i] &&
                (!win_found || ch_prio[i*PRIO_W +: PRIO_W] >= best_lvl)) begin
                win_found = 1'b1;
                win_idx   = IDX_W'(i);
                best_lvl  = ch_prio[i*PRIO_W +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/dma_grant_ctrl.sv
// Module: dma_grant_ctrl
// Holds the grant while the engine moves one data item and reloads it from
// the current winner when idle or when the engine reports completion.
// Assumes: xfer_done is a one-cycle pulse issued only while a grant is held.
module dma_grant_ctrl #(
    parameter int NUM_CH = 7,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_found,
    input  logic [IDX_W-1:0]  win_idx,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] grant,
    output logic [IDX_W-1:0]  grant_idx,
    output logic              grant_valid
);

    logic reload;

    // Reload when nothing is granted or the current item has completed.
    assign reload = !grant_valid || xfer_done;

    // Grant registers: cleared in reset, loaded from the winner on reload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant       <= '0;
            grant_idx   <= '0;
            grant_valid <= 1'b0;
        end else if (reload) begin
            grant_valid <= win_found;
            grant_idx   <= win_found ? win_idx : '0;
            grant       <= win_found ? (NUM_CH'(1) << win_idx) : '0;
        end
    end

endmodule

// File: rtl/dma_req_arbiter.sv
// Module: dma_req_arbiter (top)
// Routes peripheral requests to the DMA channels and grants one channel at a
// time by programmable level, lower index first on ties.
// Assumes: configuration inputs are stable while a grant they affect is held.
module dma_req_arbiter #(
    parameter int NUM_CH  = 7,
    parameter int NUM_SRC = 42,
    parameter int SEL_W   = 4,
    parameter int PRIO_W  = 2,
    parameter int N_CODES = 5,
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        periph_req,
    input  logic [NUM_CH-1:0]         ch_en,
    input  logic [NUM_CH-1:0]         ch_m2m,
    input  logic [NUM_CH*PRIO_W-1:0]  ch_prio,
    input  logic [NUM_CH*SEL_W-1:0]   ch_sel,
    input  logic                      xfer_done,
    output logic [NUM_CH-1:0]         grant,
    output logic [IDX_W-1:0]          grant_idx,
    output logic                      grant_valid
);

    logic [NUM_CH-1:0] chan_req;
    logic              win_found;
    logic [IDX_W-1:0]  win_idx;

    dma_req_route #(
        .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W), .N_CODES(N_CODES)
    ) u_route (
        .periph_req(periph_req),
        .ch_en     (ch_en),
        .ch_m2m    (ch_m2m),
        .ch_sel    (ch_sel),
        .chan_req  (chan_req)
    );

    dma_prio_pick #(
        .NUM_CH(NUM_CH), .PRIO_W(PRIO_W)
    ) u_pick (
        .chan_req (chan_req),
        .ch_prio  (ch_prio),
        .win_found(win_found),
        .win_idx  (win_idx)
    );

    dma_grant_ctrl #(
        .NUM_CH(NUM_CH)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .win_found  (win_found),
        .win_idx    (win_idx),
        .xfer_done  (xfer_done),
        .grant      (grant),
        .grant_idx  (grant_idx),
        .grant_valid(grant_valid)
    );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
// Module: dma_req_arbiter_chk
// Property checker attached to every dma_req_arbiter instance.
module dma_req_arbiter_chk #(
    parameter int NUM_CH = 7,
    localparam int IDX_W = $clog2(NUM_CH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_en,
    input logic              xfer_done,
    input logic [NUM_CH-1:0] grant,
    input logic [IDX_W-1:0]  grant_idx,
    input logic              grant_valid
);

    // R10: at most one channel granted
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R10: valid flag agrees with the grant vector
    a_r10_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != '0));

    // R10: index agrees with the one-hot vector
    a_r10_idx_match: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (grant == (NUM_CH'(1) << grant_idx)));

    // R9: a held grant does not move before completion
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !xfer_done) |=> ($stable(grant) && $stable(grant_idx)));

    // R5: with every channel disabled, a reload yields no grant
    a_r5_disabled_none: assert property (@(posedge clk) disable iff (!rst_n)
        ((!grant_valid || xfer_done) && ch_en == '0) |=> !grant_valid);

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ch_en      (ch_en),
    .xfer_done  (xfer_done),
    .grant      (grant),
    .grant_idx  (grant_idx),
    .grant_valid(grant_valid)
);

// File: tb/sim_dma_req_arbiter.sv
`timescale 1ns/1ps
module sim_dma_req_arbiter;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [41:0] periph_req;
    logic [6:0]  ch_en, ch_m2m;
    logic [13:0] ch_prio;
    logic [27:0] ch_sel;
    logic        xfer_done;
    logic [6:0]  grant;
    logic [2:0]  grant_idx;
    logic        grant_valid;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    dma_req_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req), .ch_en(ch_en),
        .ch_m2m(ch_m2m), .ch_prio(ch_prio), .ch_sel(ch_sel),
        .xfer_done(xfer_done), .grant(grant), .grant_idx(grant_idx),
        .grant_valid(grant_valid)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [6:0] exp_g);
        logic [2:0] exp_i = 3'd0;
        logic       exp_v = (exp_g != 7'd0);
        for (int i = 0; i < 7; i++) if (exp_g[i]) exp_i = 3'(i);
        checks++;
        if (grant !== exp_g || grant_valid !== exp_v || grant_idx !== exp_i) begin
            errors++;
            $display("FAIL %s: grant=%b idx=%0d valid=%b expected grant=%b idx=%0d valid=%b",
                     req, grant, grant_idx, grant_valid, exp_g, exp_i, exp_v);
        end
    endtask

    task automatic set_sel(input int c, input logic [3:0] code);
        ch_sel[c*4 +: 4] = code;
    endtask

    task automatic set_prio(input int c, input logic [1:0] lvl);
        ch_prio[c*2 +: 2] = lvl;
    endtask

    // Clear all stimulus and release any grant.
    task automatic clear_all();
        periph_req = '0; ch_en = '0; ch_m2m = '0; ch_prio = '0; ch_sel = '0;
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; periph_req = '1; ch_en = '1; ch_m2m = '1;
        ch_prio = '1; ch_sel = '0; xfer_done = 1'b0;
        tick(); tick();
        chk("R1 in reset", 7'd0);
        periph_req = '0; ch_en = '0; ch_m2m = '0;
        rst_n = 1'b1;
        tick();
        chk("R1 after reset", 7'd0);
    endtask

    task automatic t_route();
        for (int c = 0; c < 7; c++) begin
            clear_all();
            ch_en[c] = 1'b1; set_sel(c, 4'd2);
            periph_req[c + 7*3] = 1'b1;             // code 3 line: no effect
            periph_req[(c + 1) % 7 + 7*2] = 1'b1;   // other channel: no effect
            tick();
            chk("R2 unselected line ignored", 7'd0);
            periph_req[c + 7*2] = 1'b1;
            tick();
            chk("R2 routed line", 7'(1) << c);
        end
        clear_all();
        ch_en[4] = 1'b1; set_sel(4, 4'd4); periph_req[32] = 1'b1;
        tick();
        chk("R2 code 4 on channel 4", 7'b0010000);
    endtask

    task automatic t_or();
        clear_all();
        ch_en[2] = 1'b1; set_sel(2, 4'd0); periph_req[2] = 1'b1;
        tick();
        chk("R3 first shared line", 7'b0000100);
        clear_all();
        ch_en[2] = 1'b1; set_sel(2, 4'd0); periph_req[37] = 1'b1;
        tick();
        chk("R3 second shared line", 7'b0000100);
    endtask

    task automatic t_m2m();
        clear_all();
        ch_en[6] = 1'b1; ch_m2m[6] = 1'b1; set_sel(6, 4'd11);
        tick();
        chk("R4 self request", 7'b1000000);
    endtask

    task automatic t_disabled();
        clear_all();
        ch_m2m[3] = 1'b1; set_sel(3, 4'd1); periph_req[10] = 1'b1;
        tick();
        chk("R5 disabled channel", 7'd0);
    endtask

    task automatic t_unmapped();
        clear_all();
        ch_en[1] = 1'b1; set_sel(1, 4'd9); periph_req = '1;
        tick();
        chk("R6 code 9", 7'd0);
        set_sel(1, 4'd5);
        tick();
        chk("R6 code 5", 7'd0);
    endtask

    task automatic t_prio();
        clear_all();
        ch_en = 7'b0100001; ch_m2m = 7'b0100001;
        set_prio(0, 2'b01); set_prio(5, 2'b11);
        tick();
        chk("R7 level 11 beats 01", 7'b0100000);
        clear_all();
        ch_en = 7'b0000110; ch_m2m = 7'b0000110;
        set_prio(1, 2'b00); set_prio(2, 2'b10);
        tick();
        chk("R7 level 10 beats 00", 7'b0000100);
    endtask

    task automatic t_tie();
        clear_all();
        ch_en = 7'b0010010; ch_m2m = 7'b0010010;
        set_prio(1, 2'b10); set_prio(4, 2'b10);
        tick();
        chk("R8 tie lower index", 7'b0000010);
    endtask

    task automatic t_hold();
        clear_all();
        ch_en[3] = 1'b1; ch_m2m[3] = 1'b1; set_prio(3, 2'b00);
        tick();
        chk("R9 first grant", 7'b0001000);
        ch_en[0] = 1'b1; ch_m2m[0] = 1'b1; set_prio(0, 2'b11);
        tick(); tick();
        chk("R9 held without done", 7'b0001000);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R9 reload on done", 7'b0000001);
        ch_en = '0;
        tick();
        chk("R9 held after requests drop", 7'b0000001);
        xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
        chk("R9 release to idle", 7'd0);
    endtask

    initial begin
        t_reset();
        t_route();
        t_or();
        t_m2m();
        t_disabled();
        t_unmapped();
        t_prio();
        t_tie();
        t_hold();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule